// File: doc/BRIEF.md
# Logarithmic-Depth Recurrence Adder

This block adds two unsigned N-bit operands in pure combinational logic and returns an N-bit sum with a carry out. The carry chain is treated as a first-order Boolean recurrence: each bit supplies an OR term that lets a carry pass and an AND term that creates one. A parallel recurrence solver combines these pairs over doubling distances, so the carry network is log2 N combining levels deep rather than N.

Each sum bit is built from a half-sum and the carry arriving from the bit below. Only two-input AND and OR gates and inverters are used; the half-sum and the final sum bit are both composed from those gates, without an exclusive-OR primitive. The carry into the least significant bit is fixed at zero. The block has no clock and no storage. A caller places it between its own registers.

Top module: `rec_adder`

## Requirements
- R1: For any operands, the value {cout, s} equals the unsigned (N+1)-bit sum of a and b.
- R2: The carry into bit 0 is zero: with a = 0 and b = 0 the outputs are all zero, and with a = 1 and b = 0 the sum is 1 and cout is 0.
- R3: Sum bit i is 1 exactly when an odd number of a[i], b[i] and the carry into bit i are 1 (one of them, or all three).
- R4: The carry out of bit i is 1 exactly when at least two of a[i], b[i] and the carry into bit i are 1. A bit where exactly one operand bit is 1 passes its incoming carry through unchanged.
- R5: A carry created in bit 0 travels through every higher bit that passes it: all-ones plus 1 gives s = 0 and cout = 1.
- R6: cout is the carry out of bit N-1: all-ones plus all-ones gives cout = 1 and s equal to all ones with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| s | output | N | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The checks inside the logic assume that N is a power of two and that a and b hold known 0/1 values. They also assume the combinational network has settled before it is judged. The stimulus drives both operands together once per clock, away from the sampling point, and never drives unknown values. The random operands come from a fixed seed. The directed cases cover the longest carry run, the all-ones sum, alternating bit patterns, and a carry being created or passed at chosen bit positions.

// File: rtl/adder_pkg.sv
// Shared helpers for the recurrence adder.
// Assumes: widths are given as positive integers.
package adder_pkg;

    // Returns 1 when w is a power of two of at least 2.
    function automatic bit width_ok(input int w);
        return (w >= 2) && ((w & (w - 1)) == 0);
    endfunction

endpackage

// File: rtl/adder_pg.sv
// Per-bit pass (OR) and create (AND) terms of the carry recurrence.
// Assumes: operands are plain N-bit vectors. One gate level.
module adder_pg #(
    parameter int N = 32
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] x,
    output logic [N-1:0] y
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // pass term and create term for bit i
            assign x[i] = a[i] | b[i];
            assign y[i] = a[i] & b[i];
        end
    endgenerate

endmodule

// File: rtl/adder_solver.sv
// Solves c[i] = y[i] | (x[i] & c[i-1]) with c[-1] = 0 over log2(N) levels.
// Level k merges each bit with the bit 2^k below it, so after the last
// level every position holds its own carry out.
// Assumes: N is a power of two.
module adder_solver #(
    parameter int N   = 32,
    localparam int LVL = $clog2(N)
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] c
);

    logic [N-1:0] gen_l [0:LVL];
    logic [N-1:0] pas_l [0:LVL-1];

    assign gen_l[0] = y;
    assign pas_l[0] = x;

    generate
        for (genvar k = 0; k < LVL; k++) begin : g_lvl
            localparam int D = 1 << k;
            for (genvar i = 0; i < N; i++) begin : g_pos
                if (i >= D) begin : g_merge
                    // fold in the span that ends 2^k bits lower
                    assign gen_l[k+1][i] = gen_l[k][i] | (pas_l[k][i] & gen_l[k][i-D]);
                    if (k + 1 < LVL) begin : g_pnext
                        // pass term of the widened span
                        assign pas_l[k+1][i] = pas_l[k][i] & pas_l[k][i-D];
                    end
                end else begin : g_keep
                    // span already reaches bit 0, where the carry in is zero
                    assign gen_l[k+1][i] = gen_l[k][i];
                    if (k + 1 < LVL) begin : g_pkeep
                        // carried unchanged
                        assign pas_l[k+1][i] = pas_l[k][i];
                    end
                end
            end
        end
    endgenerate

    assign c = gen_l[LVL];

    // Checks that the solved carries obey the per-bit recurrence.
    always_comb begin
        a_r4_bit0_carry: assert (c[0] == y[0])
            else $error("R4: carry of bit 0 differs from its create term");
        for (int i = 1; i < N; i++) begin
            a_r4_pass_through: assert (!(x[i] && !y[i]) || (c[i] == c[i-1]))
                else $error("R4: passing bit %0d did not forward its carry", i);
            a_r4_create_sets: assert (!y[i] || c[i])
                else $error("R4: creating bit %0d has no carry out", i);
            a_r4_kill_clears: assert (x[i] || !c[i])
                else $error("R4: killing bit %0d has a carry out", i);
        end
    end

endmodule

// File: rtl/adder_sum.sv
// Forms half-sums and sum bits from the pass/create terms and the carries.
// Assumes: c[i] is the carry out of bit i; the carry into bit 0 is zero.
module adder_sum #(
    parameter int N = 32
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] c,
    output logic [N-1:0] s,
    output logic         cout
);

    logic [N-1:0] half;
    logic [N-1:0] cin;

    // carry into each bit; bit 0 receives zero
    assign cin = {c[N-2:0], 1'b0};

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // half-sum: exactly one operand bit set
            assign half[i] = x[i] & ~y[i];
            // select the half-sum or its inverse by the incoming carry
            assign s[i] = (half[i] & ~cin[i]) | (~half[i] & cin[i]);
        end
    endgenerate

    assign cout = c[N-1];

    // Checks sum bits where both operand bits are set.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            a_r3_both_set: assert (!y[i] || (s[i] == cin[i]))
                else $error("R3: bit %0d with both operands set mismatches carry", i);
        end
    end

endmodule

// File: rtl/rec_adder.sv
// Unsigned N-bit adder whose carries come from a log-depth recurrence
// solver. Purely combinational; carry in is zero.
// Assumes: N is a power of two of at least 2.
module rec_adder #(
    parameter int N = 32
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] s,
    output logic         cout
);

    import adder_pkg::*;

    logic [N-1:0] x;
    logic [N-1:0] y;
    logic [N-1:0] c;

    adder_pg #(.N(N)) u_pg (
        .a (a),
        .b (b),
        .x (x),
        .y (y)
    );

    adder_solver #(.N(N)) u_solver (
        .x (x),
        .y (y),
        .c (c)
    );

    adder_sum #(.N(N)) u_sum (
        .x    (x),
        .y    (y),
        .c    (c),
        .s    (s),
        .cout (cout)
    );

    // Checks the chosen width once.
    initial begin
        a_r1_width_pow2: assert (width_ok(N))
            else $error("R1: width %0d is not a power of two", N);
    end

    // Checks the full result against arithmetic addition.
    always_comb begin
        a_r1_sum_value: assert ({cout, s} == ({1'b0, a} + {1'b0, b}))
            else $error("R1: adder result differs from a+b");
    end

endmodule

// File: tb/sim_rec_adder.sv
module sim_rec_adder;

    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [N-1:0] s;
    logic         cout;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rec_adder #(.N(N)) u0 (
        .a    (a),
        .b    (b),
        .s    (s),
        .cout (cout)
    );

    // Counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Bit-serial reference: returns {cout, s}.
    function automatic logic [N:0] ref_add(input logic [N-1:0] p, input logic [N-1:0] q);
        logic [N:0] r;
        logic cy;
        cy = 1'b0;
        for (int i = 0; i < N; i++) begin
            r[i] = p[i] ^ q[i] ^ cy;
            cy = (p[i] & q[i]) | (p[i] & cy) | (q[i] & cy);
        end
        r[N] = cy;
        return r;
    endfunction

    // Reference carry out of bit k.
    function automatic logic ref_carry(input logic [N-1:0] p, input logic [N-1:0] q, input int k);
        logic cy;
        cy = 1'b0;
        for (int i = 0; i <= k; i++)
            cy = (p[i] & q[i]) | (p[i] & cy) | (q[i] & cy);
        return cy;
    endfunction

    task automatic apply(input logic [N-1:0] p, input logic [N-1:0] q);
        @(negedge clk);
        a = p;
        b = q;
        #5;
    endtask

    task automatic check_word(input string req, input logic [N:0] exp);
        total = total + 1;
        if ({cout, s} !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, a, b, {cout, s}, exp);
        end
    endtask

    // R3/R4: checks every sum bit and, through the sum of the bit above, each carry.
    task automatic check_bits(input string req);
        logic exp_bit;
        logic cin_k;
        for (int k = 0; k < N; k++) begin
            cin_k = (k == 0) ? 1'b0 : ref_carry(a, b, k - 1);
            exp_bit = a[k] ^ b[k] ^ cin_k;
            total = total + 1;
            if (s[k] !== exp_bit) begin
                bad = bad + 1;
                $display("FAIL %s: bit %0d actual=%b expected=%b", req, k, s[k], exp_bit);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R2: zero operands give zero result
        apply('0, '0);
        check_word("R2 zero", '0);
        // R2: no hidden carry in
        apply(N'(1), '0);
        check_word("R2 one", {1'b0, N'(1)});
        // R5: carry ripples across the full width
        apply('1, N'(1));
        check_word("R5 full ripple", {1'b1, {N{1'b0}}});
        apply(N'(1), '1);
        check_word("R5 full ripple swapped", {1'b1, {N{1'b0}}});
        // R6: cout from the top bit
        apply('1, '1);
        check_word("R6 all ones", {1'b1, {(N-1){1'b1}}, 1'b0});
        apply({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}});
        check_word("R6 top bits", {1'b1, {N{1'b0}}});
        // R1: alternating patterns
        apply({(N/2){2'b10}}, {(N/2){2'b01}});
        check_word("R1 alternating", {1'b0, {N{1'b1}}});
        apply({(N/2){2'b10}}, {(N/2){2'b10}});
        check_word("R1 alternating doubled", ref_add({(N/2){2'b10}}, {(N/2){2'b10}}));
        // R3 and R4: carry created at chosen positions then passed
        for (int k = 0; k < N; k += 5) begin
            apply((N'(1) << k) | ({N{1'b1}} << (k + 1)), N'(1) << k);
            check_bits("R3 R4 created carry");
            check_word("R4 created carry", ref_add(a, b));
        end
        // R1 R3: random vectors
        for (int n = 0; n < 1500; n++) begin
            apply(N'($urandom), N'($urandom));
            check_word("R1 random", ref_add(a, b));
            if (n % 50 == 0) check_bits("R3 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule